// File: doc/BRIEF.md
# Framed Packet Receiver and Checker

This block sits behind a serial byte receiver and turns a raw stream of bytes, each qualified by a one-cycle valid strobe, into checked messages carrying compressed image data. It waits for an opening marker and discards any bytes that come before one. It then captures a small header: a message kind, a wide target address and a size code.

The payload bytes that follow the header are written, one per byte, into a local buffer RAM. Each frame's payload starts at buffer address zero. While the frame arrives, a running CRC-8 covers the header and the payload. The transmitted check byte is compared against this CRC, and the frame closes with a trailing marker.

When the trailing byte arrives, the block raises a one-cycle completion strobe with a pass/fail status. The captured header values stay on the outputs for the consumer, which starts the transfer to external memory only when the status is good.

Top module: `pkt_frame_rx`

## Requirements
- R1: While hunting, every byte other than the opening marker 0xA5 is discarded: it produces no buffer write and no completion strobe, and the captured header outputs keep their values.
- R2: After the opening marker, the next byte is captured as `msg_type`, the following three bytes form `msg_addr` (the first received byte lands in bits 23:16 and the last in bits 7:0), and the byte after them is captured as `msg_len`.
- R3: The payload that follows the header holds exactly (msg_len + 1) × 4 bytes, so it spans 4 to 1024 bytes.
- R4: Every payload byte produces exactly one buffer write, one cycle after the byte is accepted. Write addresses run 0, 1, 2, … within each frame, and `buf_data` equals the payload byte.
- R5: The CRC is CRC-8 with polynomial x^8+x^2+x+1 (0x07) and initial value 0x00, shifted most significant bit first. It covers the type byte through the last payload byte. The byte that follows the payload must equal this CRC for the status to be good.
- R6: The byte after the check byte must be the closing marker 0x5A. One cycle after this byte is accepted, `done` pulses high for one cycle. `ok` is high only when both the check byte and the closing marker are correct. When the closing byte is wrong, `done` still pulses with `ok` low.
- R7: After `done`, the receiver returns to hunting. `msg_type`, `msg_addr` and `msg_len` hold their values until header bytes of the next frame are accepted.
- R8: A synchronous reset, `rst` high, returns the receiver to hunting and clears all of the following: `done`, `ok`, `buf_we`, `buf_addr`, `buf_data` and every captured field. This holds even when the reset arrives in the middle of a frame.
- R9: A cycle with `rx_valid` low has no effect, whatever value `rx_byte` holds. In the next cycle there is no write and no `done`, and the header outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | `rx_byte` holds a new byte this cycle |
| rx_byte | input | 8 | Received byte |
| buf_we | output | 1 | Write enable to the payload buffer |
| buf_addr | output | 10 | Buffer write address |
| buf_data | output | 8 | Buffer write data |
| done | output | 1 | One-cycle frame completion strobe |
| ok | output | 1 | Frame status, valid with `done` (1 = good) |
| msg_type | output | 8 | Captured message type |
| msg_addr | output | 24 | Captured target address |
| msg_len | output | 8 | Captured size code |

## Verification
The checker watches several properties on every cycle:
- the completion strobe lasts exactly one cycle;
- buffer write addresses climb from zero without gaps;
- the number of writes in a frame matches the size code when `done` fires;
- idle cycles cause no write, no strobe and no field change;
- reset clears the outputs.

Some behaviours depend on the byte values the bench computes on its own side, so only the bench scenarios can show them:
- that the CRC matches the stated polynomial;
- that address bytes land in the right order;
- that garbage before the marker is skipped;
- that a corrupted check byte or closing byte gives a failing status followed by a clean next frame.

// File: rtl/pkt_frame_pkg.sv
package pkt_frame_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_KIND,
        ST_ADDR,
        ST_SIZE,
        ST_BODY,
        ST_CHECK,
        ST_TAIL
    } rx_state_e;

    // One byte through a CRC-8 register, most significant bit first.
    function automatic logic [7:0] crc8_byte(input logic [7:0] crc,
                                             input logic [7:0] din,
                                             input logic [7:0] poly);
        logic [7:0] c;
        c = crc ^ din;
        for (int i = 0; i < 8; i++) begin
            if (c[7]) c = {c[6:0], 1'b0} ^ poly;
            else      c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/pkt_crc_acc.sv
module pkt_crc_acc #(
    parameter logic [7:0] POLY = 8'h07,
    parameter logic [7:0] INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    import pkt_frame_pkg::*;

    logic [7:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr)     crc_d = INIT;
        else if (en) crc_d = crc8_byte(crc_q, din, POLY);
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= INIT;
        else     crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/pkt_buf_port.sv
module pkt_buf_port #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [7:0]    data
);
    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d    = p_q;
        p_d.we = wr_en;
        if (wr_en) begin
            p_d.addr = wr_addr;
            p_d.data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign we   = p_q.we;
    assign addr = p_q.addr;
    assign data = p_q.data;
endmodule

// File: rtl/pkt_frame_rx.sv
module pkt_frame_rx #(
    parameter logic [7:0] SOF_BYTE   = 8'hA5,
    parameter logic [7:0] EOF_BYTE   = 8'h5A,
    parameter logic [7:0] CRC_POLY   = 8'h07,
    parameter logic [7:0] CRC_INIT   = 8'h00,
    parameter int         ADDR_BYTES = 3,
    parameter int         LEN_UNIT   = 4,
    parameter int         BUF_AW     = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    output logic                    buf_we,
    output logic [BUF_AW-1:0]       buf_addr,
    output logic [7:0]              buf_data,
    output logic                    done,
    output logic                    ok,
    output logic [7:0]              msg_type,
    output logic [8*ADDR_BYTES-1:0] msg_addr,
    output logic [7:0]              msg_len
);
    import pkt_frame_pkg::*;

    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int CW     = BUF_AW + 1;
    localparam int AIW    = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    typedef struct packed {
        rx_state_e      st;
        logic [AIW-1:0] aidx;
        logic [CW-1:0]  cnt;
        logic [CW-1:0]  total;
        logic           crc_good;
        logic [7:0]     kind;
        logic [ADDR_W-1:0] addr;
        logic [7:0]     size;
        logic           done;
        logic           ok;
    } rx_reg_t;

    rx_reg_t r_d, r_q;
    logic       crc_clr, crc_en, wr_en;
    logic [7:0] crc_now;

    pkt_crc_acc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk (clk),
        .rst (rst),
        .clr (crc_clr),
        .en  (crc_en),
        .din (rx_byte),
        .crc (crc_now)
    );

    pkt_buf_port #(.AW(BUF_AW)) u_port (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (r_q.cnt[BUF_AW-1:0]),
        .wr_data (rx_byte),
        .we      (buf_we),
        .addr    (buf_addr),
        .data    (buf_data)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        wr_en    = 1'b0;
        if (rx_valid) begin
            case (r_q.st)
                ST_HUNT: begin
                    if (rx_byte == SOF_BYTE) begin
                        crc_clr = 1'b1;
                        r_d.st  = ST_KIND;
                    end
                end
                ST_KIND: begin
                    crc_en   = 1'b1;
                    r_d.kind = rx_byte;
                    r_d.aidx = '0;
                    r_d.st   = ST_ADDR;
                end
                ST_ADDR: begin
                    crc_en   = 1'b1;
                    r_d.addr = (r_q.addr << 8) | ADDR_W'(rx_byte);
                    if (r_q.aidx == AIW'(ADDR_BYTES - 1)) r_d.st = ST_SIZE;
                    else r_d.aidx = r_q.aidx + 1'b1;
                end
                ST_SIZE: begin
                    crc_en    = 1'b1;
                    r_d.size  = rx_byte;
                    r_d.total = CW'((32'(rx_byte) + 1) * LEN_UNIT);
                    r_d.cnt   = '0;
                    r_d.st    = ST_BODY;
                end
                ST_BODY: begin
                    crc_en  = 1'b1;
                    wr_en   = 1'b1;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == r_q.total - 1'b1) r_d.st = ST_CHECK;
                end
                ST_CHECK: begin
                    r_d.crc_good = (rx_byte == crc_now);
                    r_d.st       = ST_TAIL;
                end
                ST_TAIL: begin
                    r_d.done = 1'b1;
                    r_d.ok   = r_q.crc_good && (rx_byte == EOF_BYTE);
                    r_d.st   = ST_HUNT;
                end
                default: r_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.st <= ST_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign done     = r_q.done;
    assign ok       = r_q.ok;
    assign msg_type = r_q.kind;
    assign msg_addr = r_q.addr;
    assign msg_len  = r_q.size;
endmodule

// File: rtl/pkt_frame_rx_chk.sv
module pkt_frame_rx_chk #(
    parameter int ADDR_W   = 24,
    parameter int LEN_UNIT = 4,
    parameter int BUF_AW   = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              buf_we,
    input logic [BUF_AW-1:0] buf_addr,
    input logic              done,
    input logic              ok,
    input logic [7:0]        msg_type,
    input logic [ADDR_W-1:0] msg_addr,
    input logic [7:0]        msg_len
);
    logic [BUF_AW:0] wcnt_q;

    always_ff @(posedge clk) begin
        if (rst || done)  wcnt_q <= '0;
        else if (buf_we)  wcnt_q <= wcnt_q + 1'b1;
    end

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_wr_sequence_R4: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (buf_addr == wcnt_q[BUF_AW-1:0]));

    assert_wr_total_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (32'(wcnt_q) == (32'(msg_len) + 1) * LEN_UNIT));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> (!buf_we && !done && $stable(msg_type)
                       && $stable(msg_addr) && $stable(msg_len)));

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!done && !ok && !buf_we && msg_type == '0
                 && msg_addr == '0 && msg_len == '0));
endmodule

bind pkt_frame_rx pkt_frame_rx_chk #(
    .ADDR_W   (8 * ADDR_BYTES),
    .LEN_UNIT (LEN_UNIT),
    .BUF_AW   (BUF_AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .buf_we   (buf_we),
    .buf_addr (buf_addr),
    .done     (done),
    .ok       (ok),
    .msg_type (msg_type),
    .msg_addr (msg_addr),
    .msg_len  (msg_len)
);

// File: tb/sim_pkt_frame_rx.sv
`timescale 1ns/1ps
module sim_pkt_frame_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        buf_we, done, ok;
    logic [9:0]  buf_addr;
    logic [7:0]  buf_data, msg_type, msg_len;
    logic [23:0] msg_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int wcnt = 0, addr_err = 0, ndone = 0;
    logic got_ok;
    logic [7:0] got_mem [1024];
    logic [7:0] pay     [1024];

    always #5 clk = ~clk;

    pkt_frame_rx u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
        .done(done), .ok(ok), .msg_type(msg_type), .msg_addr(msg_addr),
        .msg_len(msg_len)
    );

    // Output monitor, sampled 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (buf_we) begin
            if (32'(buf_addr) != wcnt) addr_err++;
            got_mem[buf_addr] = buf_data;
            wcnt++;
        end
        if (done) begin
            ndone++;
            got_ok = ok;
        end
    end

    // Bit-serial reference CRC: feedback = top bit xor data bit, 0x07 taps.
    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
        logic fb;
        for (int k = 7; k >= 0; k--) begin
            fb = c[7] ^ b[k];
            c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'(($urandom % 2) ? 8'hA5 : $urandom);
        repeat ($urandom % 3) @(negedge clk);
    endtask

    task automatic clear_mon();
        wcnt = 0; addr_err = 0; ndone = 0; got_ok = 1'bx;
    endtask

    task automatic frame(input logic [7:0] typ, input logic [23:0] adr, input logic [7:0] len,
                         input bit bad_crc, input bit bad_eof);
        logic [7:0] c;
        int n;
        n = (int'(len) + 1) * 4;
        clear_mon();
        c = 8'h00;
        put(8'hA5);
        put(typ);  c = ref_crc(c, typ);
        for (int i = 2; i >= 0; i--) begin
            put(adr[8*i +: 8]); c = ref_crc(c, adr[8*i +: 8]);
        end
        put(len); c = ref_crc(c, len);
        for (int i = 0; i < n; i++) begin
            pay[i] = 8'($urandom);
            put(pay[i]); c = ref_crc(c, pay[i]);
        end
        put(bad_crc ? (c ^ 8'h10) : c);
        put(bad_eof ? 8'h5B : 8'h5A);
        repeat (2) @(negedge clk);
        check("R2", "type", msg_type, typ);
        check("R2", "addr", msg_addr, adr);
        check("R2", "len", msg_len, len);
        check("R3", "write count", wcnt, n);
        check("R4", "address order errors", addr_err, 0);
        begin
            int mism = 0;
            for (int i = 0; i < n; i++) if (got_mem[i] !== pay[i]) mism++;
            check("R4", "payload mismatches", mism, 0);
        end
        check("R6", "done pulses", ndone, 1);
        check(bad_crc ? "R5" : "R6", "status", got_ok, !(bad_crc || bad_eof));
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8", "done at reset", done, 0);
        check("R8", "we at reset", buf_we, 0);
        check("R8", "fields at reset", {msg_type, msg_addr, msg_len}, 0);
        rst = 1'b0;

        // R9 idle noise with valid low, including marker values
        clear_mon();
        repeat (10) begin @(negedge clk); rx_byte = ($urandom % 2) ? 8'hA5 : 8'h5A; end
        @(negedge clk);
        check("R9", "writes when idle", wcnt, 0);
        check("R9", "done when idle", ndone, 0);

        // R1 garbage before marker, then a shortest frame
        clear_mon();
        for (int i = 0; i < 20; i++) begin
            logic [7:0] g = 8'($urandom);
            if (g == 8'hA5) g = 8'h00;
            put(g);
        end
        check("R1", "writes from garbage", wcnt, 0);
        check("R1", "done from garbage", ndone, 0);
        check("R1", "fields untouched", {msg_type, msg_addr, msg_len}, 0);
        frame(8'h01, 24'h123456, 8'd0, 0, 0);

        // R7 fields hold across garbage after a frame
        clear_mon();
        for (int i = 0; i < 8; i++) put(8'h33);
        check("R7", "type held", msg_type, 8'h01);
        check("R7", "addr held", msg_addr, 24'h123456);
        check("R1", "no done from garbage", ndone, 0);

        // R3 largest frame
        frame(8'h7E, 24'hABCDEF, 8'd255, 0, 0);
        // R5 corrupted check byte, R6 wrong closing byte, then recovery (R7)
        frame(8'h02, 24'h000100, 8'd3, 1, 0);
        frame(8'h03, 24'hFF0001, 8'd2, 0, 1);
        frame(8'h04, 24'h800000, 8'd1, 0, 0);

        // R8 reset in the middle of a frame
        put(8'hA5); put(8'h09); put(8'h11); put(8'h22); put(8'h33); put(8'd4);
        put(8'h44); put(8'h55);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R8", "fields after mid reset", {msg_type, msg_addr, msg_len}, 0);
        check("R8", "status after mid reset", {done, ok, buf_we}, 0);

        // Random frames
        for (int f = 0; f < 12; f++) begin
            int sel = $urandom % 6;
            frame(8'($urandom), 24'($urandom), 8'($urandom % 32), sel == 0, sel == 1);
        end
        finish_up();
    end
endmodule